// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits on the device side of a byte-wide parallel flash bus. It watches each accepted write cycle, which carries an address and a data byte. It tracks the multi-cycle unlock sequences that select an operation. All commands share the same two-cycle unlock prefix. The third cycle either finishes the command or branches into a second unlock pair that leads to chip erase or to boot-region lockout.

When a command completes, the block issues a single-cycle pulse to the program/erase engine and supplies the operation operands with it. It also keeps a sticky boot-lock flag and a product-identification read mode. In identification mode, reads return identification bytes and the lock status instead of array data.

Boot-region protection is applied here. While the lock flag is set, a program whose target is at or below the boot-region top produces no pulse. An erase pulse carries a keep-boot qualifier that tells the engine to leave the boot region intact. The engine itself clears bits (new = old AND data) and erases to 0xFF; that arithmetic is outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the decoder is idle, both pulses are low, identification mode is off and the boot-lock flag is 0.
- R2: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 followed by a fourth write to any address assert prog_pulse one clock after the fourth write. In that same cycle op_addr and op_data equal the fourth write's address and data.
- R3: The six writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10 assert erase_pulse one clock after the sixth write. In that same cycle keep_boot equals the boot-lock flag.
- R4: The same six-write form ending in 0x5555/0x40 sets boot_locked one clock after the sixth write. The flag then stays set until reset, including across erase commands.
- R5: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90 set id_mode. While id_mode is set, rd_data is combinational from rd_addr:
  - address 0 returns MFR_CODE;
  - address 1 returns DEV_CODE;
  - address 2 returns {7'b0, boot_locked};
  - any other address returns 0x00.
  
  While id_mode is clear, rd_data equals arr_rdata.
- R6: id_mode clears one clock after either exit form. The first form is the three writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xF0. The second is a single write of 0xF0 to any address while the decoder is idle.
- R7: While boot_locked is 1, a program target at or below BOOT_TOP (0x01FFF) produces no prog_pulse, and a target above it produces the pulse.
- R8: A write that does not match the expected address/data pair returns the decoder to idle with no pulse and no flag change. If that mismatching write is itself 0x5555/0xAA, it is taken as the first unlock cycle.
- R9: Writes presented while busy is high are ignored: they advance no sequence and produce no pulse. Reads are still served.
- R10: prog_pulse and erase_pulse are never high together, and each lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A bus write cycle is presented this clock |
| wr_addr | input | AW | Write cycle address |
| wr_data | input | 8 | Write cycle data |
| busy | input | 1 | Program/erase engine is working |
| rd_addr | input | AW | Read address |
| arr_rdata | input | 8 | Data read from the array at rd_addr |
| rd_data | output | 8 | Read data returned to the bus |
| prog_pulse | output | 1 | Start a byte program |
| erase_pulse | output | 1 | Start a chip erase |
| keep_boot | output | 1 | Erase must leave the boot region intact |
| op_addr | output | AW | Program target address |
| op_data | output | 8 | Program data |
| boot_locked | output | 1 | Boot-region lockout flag |
| id_mode | output | 1 | Product identification read mode active |

## Verification
Every result of a write is registered. prog_pulse, erase_pulse, keep_boot, op_addr, op_data, boot_locked and id_mode all change on the clock edge that accepts the write. They are therefore due one clock after that write is presented. rd_data is combinational and is due in the same cycle as rd_addr. The bench presents each write on a falling edge and samples the registered results on the next falling edge, after exactly one rising edge. It checks the read mux a short delay after changing rd_addr, with no clock edge in between.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_PROG,
        S_EXT0,
        S_EXT1,
        S_EXT2
    } seq_state_e;

    localparam logic [7:0] KEY_A     = 8'hAA;
    localparam logic [7:0] KEY_B     = 8'h55;
    localparam logic [7:0] OP_PROG   = 8'hA0;
    localparam logic [7:0] OP_EXTEND = 8'h80;
    localparam logic [7:0] OP_ID_IN  = 8'h90;
    localparam logic [7:0] OP_ID_OUT = 8'hF0;
    localparam logic [7:0] OP_ERASE  = 8'h10;
    localparam logic [7:0] OP_LOCK   = 8'h40;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 18,
    parameter logic [AW-1:0] KEY_ADDR_A = 'h5555,
    parameter logic [AW-1:0] KEY_ADDR_B = 'h2AAA,
    parameter logic [AW-1:0] BOOT_TOP   = 'h1FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          busy,
    output logic          prog_pulse,
    output logic          erase_pulse,
    output logic          keep_boot,
    output logic [AW-1:0] op_addr,
    output logic [7:0]    op_data,
    output logic          boot_locked,
    output logic          id_mode
);

    typedef struct packed {
        seq_state_e    state;
        logic          prog;
        logic          erase;
        logic          keep;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          lock;
        logic          id;
    } regs_t;

    regs_t r_d, r_q;

    logic accept;
    logic hit_a;
    logic hit_b;
    logic at_key_a;
    logic in_boot;

    always_comb begin
        accept   = wr_en && !busy;
        at_key_a = (wr_addr == KEY_ADDR_A);
        hit_a    = at_key_a && (wr_data == KEY_A);
        hit_b    = (wr_addr == KEY_ADDR_B) && (wr_data == KEY_B);
        in_boot  = (wr_addr <= BOOT_TOP);

        r_d       = r_q;
        r_d.prog  = 1'b0;
        r_d.erase = 1'b0;

        if (accept) begin
            r_d.state = hit_a ? S_UNL1 : S_IDLE;
            unique case (r_q.state)
                S_IDLE: begin
                    if (wr_data == OP_ID_OUT) r_d.id = 1'b0;
                end
                S_UNL1: begin
                    if (hit_b) r_d.state = S_UNL2;
                end
                S_UNL2: begin
                    if (at_key_a) begin
                        unique case (wr_data)
                            OP_PROG:   r_d.state = S_PROG;
                            OP_EXTEND: r_d.state = S_EXT0;
                            OP_ID_IN:  r_d.id = 1'b1;
                            OP_ID_OUT: r_d.id = 1'b0;
                            default:   ;
                        endcase
                    end
                end
                S_PROG: begin
                    r_d.state = S_IDLE;
                    if (!(r_q.lock && in_boot)) begin
                        r_d.prog = 1'b1;
                        r_d.addr = wr_addr;
                        r_d.data = wr_data;
                    end
                end
                S_EXT0: begin
                    if (hit_a) r_d.state = S_EXT1;
                end
                S_EXT1: begin
                    if (hit_b) r_d.state = S_EXT2;
                end
                S_EXT2: begin
                    if (at_key_a && wr_data == OP_ERASE) begin
                        r_d.erase = 1'b1;
                        r_d.keep  = r_q.lock;
                    end
                    if (at_key_a && wr_data == OP_LOCK) r_d.lock = 1'b1;
                end
                default: r_d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, prog: 1'b0, erase: 1'b0, keep: 1'b0,
                     addr: '0, data: '0, lock: 1'b0, id: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_pulse  = r_q.prog;
    assign erase_pulse = r_q.erase;
    assign keep_boot   = r_q.keep;
    assign op_addr     = r_q.addr;
    assign op_data     = r_q.data;
    assign boot_locked = r_q.lock;
    assign id_mode     = r_q.id;

    // R10: the two start pulses are exclusive and one clock wide
    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_pulse && erase_pulse));
    assert_prog_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |=> !prog_pulse);
    assert_erase_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |=> !erase_pulse);
    // R7: no program pulse may target the locked boot region
    assert_boot_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_pulse && boot_locked) |-> (op_addr > BOOT_TOP));
    // R4: the lock flag never falls while out of reset
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);
    // R9: a busy engine blocks any new start
    assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!prog_pulse && !erase_pulse));
    // R8: a broken prefix never reaches the command-selection step
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && r_q.state == S_UNL1 && !hit_b) |=> (r_q.state != S_UNL2));

endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux #(
    parameter int AW = 18,
    parameter logic [7:0] MFR_CODE = 8'hA5,
    parameter logic [7:0] DEV_CODE = 8'h5B
) (
    input  logic          id_mode,
    input  logic          boot_locked,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    arr_rdata,
    output logic [7:0]    rd_data
);

    always_comb begin
        if (!id_mode) begin
            rd_data = arr_rdata;
        end else begin
            unique case (rd_addr)
                AW'(0):  rd_data = MFR_CODE;
                AW'(1):  rd_data = DEV_CODE;
                AW'(2):  rd_data = {7'b0, boot_locked};
                default: rd_data = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
    parameter int AW = 18,
    parameter logic [AW-1:0] KEY_ADDR_A = 'h5555,
    parameter logic [AW-1:0] KEY_ADDR_B = 'h2AAA,
    parameter logic [AW-1:0] BOOT_TOP   = 'h1FFF,
    parameter logic [7:0]    MFR_CODE   = 8'hA5,
    parameter logic [7:0]    DEV_CODE   = 8'h5B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          busy,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    arr_rdata,
    output logic [7:0]    rd_data,
    output logic          prog_pulse,
    output logic          erase_pulse,
    output logic          keep_boot,
    output logic [AW-1:0] op_addr,
    output logic [7:0]    op_data,
    output logic          boot_locked,
    output logic          id_mode
);

    flash_cmd_fsm #(
        .AW(AW), .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B), .BOOT_TOP(BOOT_TOP)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .prog_pulse(prog_pulse), .erase_pulse(erase_pulse),
        .keep_boot(keep_boot), .op_addr(op_addr), .op_data(op_data),
        .boot_locked(boot_locked), .id_mode(id_mode)
    );

    flash_id_mux #(
        .AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_mux (
        .id_mode(id_mode), .boot_locked(boot_locked), .rd_addr(rd_addr),
        .arr_rdata(arr_rdata), .rd_data(rd_data)
    );

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

    localparam int AW = 18;
    localparam int NV = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    arr_rdata = 8'h3C;
    logic [7:0]    rd_data;
    logic          prog_pulse, erase_pulse, keep_boot, boot_locked, id_mode;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    flash_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data),
        .prog_pulse(prog_pulse), .erase_pulse(erase_pulse), .keep_boot(keep_boot),
        .op_addr(op_addr), .op_data(op_data), .boot_locked(boot_locked), .id_mode(id_mode)
    );

    // row: {req, addr, data, expected prog, erase, id after the write}
    localparam logic [32:0] VEC [NV] = '{
        {4'd2, 18'h05555, 8'hAA, 3'b000},   // R2 program
        {4'd2, 18'h02AAA, 8'h55, 3'b000},
        {4'd2, 18'h05555, 8'hA0, 3'b000},
        {4'd2, 18'h00100, 8'h3C, 3'b100},
        {4'd3, 18'h05555, 8'hAA, 3'b000},   // R3 erase
        {4'd3, 18'h02AAA, 8'h55, 3'b000},
        {4'd3, 18'h05555, 8'h80, 3'b000},
        {4'd3, 18'h05555, 8'hAA, 3'b000},
        {4'd3, 18'h02AAA, 8'h55, 3'b000},
        {4'd3, 18'h05555, 8'h10, 3'b010},
        {4'd5, 18'h05555, 8'hAA, 3'b000},   // R5 id entry
        {4'd5, 18'h02AAA, 8'h55, 3'b000},
        {4'd5, 18'h05555, 8'h90, 3'b001},
        {4'd6, 18'h01234, 8'hF0, 3'b000},   // R6 one-write exit
        {4'd5, 18'h05555, 8'hAA, 3'b000},
        {4'd5, 18'h02AAA, 8'h55, 3'b000},
        {4'd5, 18'h05555, 8'h90, 3'b001},
        {4'd6, 18'h05555, 8'hAA, 3'b001},   // R6 three-write exit
        {4'd6, 18'h02AAA, 8'h55, 3'b001},
        {4'd6, 18'h05555, 8'hF0, 3'b000},
        {4'd8, 18'h05555, 8'hAA, 3'b000},   // R8 abort
        {4'd8, 18'h02AAA, 8'h56, 3'b000},
        {4'd8, 18'h05555, 8'hA0, 3'b000},
        {4'd8, 18'h00200, 8'h00, 3'b000},
        {4'd8, 18'h05555, 8'hAA, 3'b000},   // R8 restart on key
        {4'd8, 18'h05555, 8'hAA, 3'b000},
        {4'd8, 18'h02AAA, 8'h55, 3'b000},
        {4'd8, 18'h05555, 8'hA0, 3'b000},
        {4'd8, 18'h03000, 8'h77, 3'b100}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic seq6(input logic [7:0] last);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h80);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, last);
    endtask

    task automatic seq3(input logic [7:0] last);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, last);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        rd_addr = a;
        #1;
        check(req, "rd_data", 32'(rd_data), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "prog", 32'(prog_pulse), 0);
        check("R1", "erase", 32'(erase_pulse), 0);
        check("R1", "id", 32'(id_mode), 0);
        check("R1", "lock", 32'(boot_locked), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][32:29]);
            wr(VEC[i][28:11], VEC[i][10:3]);
            check(tag, $sformatf("prog row %0d", i), 32'(prog_pulse), 32'(VEC[i][2]));
            check(tag, $sformatf("erase row %0d", i), 32'(erase_pulse), 32'(VEC[i][1]));
            check(tag, $sformatf("id row %0d", i), 32'(id_mode), 32'(VEC[i][0]));
            if (VEC[i][2]) begin
                check(tag, "op_addr", 32'(op_addr), 32'(VEC[i][28:11]));
                check(tag, "op_data", 32'(op_data), 32'(VEC[i][10:3]));
            end
            if (VEC[i][1]) check("R3", "keep_boot unlocked", 32'(keep_boot), 0);
        end
        @(negedge clk);
        check("R10", "prog one clock", 32'(prog_pulse), 0);

        // R5 reads outside id mode come from the array
        rd(18'h00002, 8'h3C, "R5");

        // R4 lockout
        seq6(8'h40);
        check("R4", "lock set", 32'(boot_locked), 1);
        check("R4", "no pulse", 32'({prog_pulse, erase_pulse}), 0);

        // R5 id reads
        seq3(8'h90);
        check("R5", "id on", 32'(id_mode), 1);
        rd(18'h00000, 8'hA5, "R5");
        rd(18'h00001, 8'h5B, "R5");
        rd(18'h00002, 8'h01, "R5");
        rd(18'h00005, 8'h00, "R5");
        wr(18'h00000, 8'hF0);
        check("R6", "id off", 32'(id_mode), 0);
        rd(18'h00002, 8'h3C, "R5");

        // R7 boot guard
        seq3(8'hA0);
        wr(18'h01FFF, 8'h12);
        check("R7", "boot top blocked", 32'(prog_pulse), 0);
        seq3(8'hA0);
        wr(18'h02000, 8'h34);
        check("R7", "above boot pulses", 32'(prog_pulse), 1);
        check("R7", "op_addr", 32'(op_addr), 32'h02000);

        // R3 erase while locked keeps boot; R4 lock survives
        seq6(8'h10);
        check("R3", "erase pulse", 32'(erase_pulse), 1);
        check("R3", "keep_boot", 32'(keep_boot), 1);
        check("R10", "prog low during erase", 32'(prog_pulse), 0);
        @(negedge clk);
        check("R10", "erase one clock", 32'(erase_pulse), 0);
        check("R4", "lock persists", 32'(boot_locked), 1);

        // R9 busy blocks writes, reads still served
        busy = 1'b1;
        seq3(8'hA0);
        wr(18'h03000, 8'h55);
        check("R9", "no prog while busy", 32'(prog_pulse), 0);
        arr_rdata = 8'h9E;
        rd(18'h03000, 8'h9E, "R9");
        seq3(8'h90);
        check("R9", "no id entry while busy", 32'(id_mode), 0);
        busy = 1'b0;
        wr(18'h03000, 8'h55);
        check("R9", "sequence not advanced", 32'(prog_pulse), 0);

        // R1 reset clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "lock cleared", 32'(boot_locked), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule